// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Generator

This block produces one pulse-width-modulated output from a bus clock. A write port loads two 32-bit words: a control word that sets the clock divider and the output options, and a duty word that sets the period and the two edge positions of the waveform. The bus clock passes through two divider stages in series, a power-of-two stage and a divide-by-(L+1) stage, and the result advances an 8-bit period counter by one tick. The output is asserted while the count lies between the falling point (inclusive) and the rising point (exclusive).

The output is then conditioned. It can be inverted, forced to its idle level, or driven in open-drain fashion, and it is tri-stated when the pin is disabled. By default, new duty words wait in a pending copy and take effect only at the next period wrap, so a running waveform never shows a torn period. A control bit can make duty writes take effect at once instead.

Top module: `pwm_chan`

## Requirements
- R1: After reset both words are zero, so `pinOe` and `pinOut` are low.
- R2: The tick lasts 2^H x (L+1) bus clocks. H is control bits 11:8 and L is control bits 7:0.
- R3: The counter steps by one per tick from 0 up to the active period P (duty bits 31:24), then returns to 0. The period therefore lasts P+1 ticks.
- R4: The waveform is asserted for counts from the falling point F (duty bits 7:0) up to, but not including, the rising point R (duty bits 15:8). When F > R the window wraps through the end of the period. When F = R the waveform is never asserted.
- R5: While control bit 16 (clock enable) is clear, the divider and the counter stay at zero and the waveform is deasserted.
- R6: While control bit 12 (pin enable) is clear, `pinOe` is low.
- R7: Control bit 14 inverts the level on `pinOut`, including the idle level.
- R8: Control bit 15 replaces the waveform with its deasserted level, so `pinOut` equals control bit 14.
- R9: With control bit 13 set, `pinOe` is high only while `pinOut` is low.
- R10: While control bit 17 is clear and the clock is enabled, a written duty word becomes active only on the clock edge where the counter wraps. A word written in that same cycle takes effect at that wrap. While the clock is disabled, a written duty word becomes active on the next edge.
- R11: With control bit 17 set, a duty word becomes active on the edge that writes it.
- R12: A write to offset 0x0 loads the control word and a write to offset 0x4 loads the duty word. Writes to any other offset change nothing. Duty bits 23:16 and control bits 31:18 are ignored.
- R13: If a new period is at or below the current count, the counter returns to 0 on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Byte offset of the write within the channel |
| wrData | input | 32 | Write data |
| pinOut | output | 1 | Conditioned output level |
| pinOe | output | 1 | Output drive enable; low means released |

## Verification
A wrong divider or counter state shows at the ports as an output edge that arrives early or late. The bench compares the pin against a behavioural model on every clock, so the mismatch is reported within one tick of the fault. A shadow copy that updates at the wrong time changes the edge position of the very next period. A slip in the conditioning logic shows on the same cycle as a wrong level or a wrong drive enable.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int CNT_W    = 8;
  localparam int DIVH_W   = 4;
  localparam int DIVL_W   = 8;
  localparam int HI_W     = (1 << DIVH_W) - 1;
  localparam int PER_LSB  = 24;
  localparam int RISE_LSB = 8;
  localparam int FALL_LSB = 0;
  localparam int DIVH_LSB = 8;
  localparam int DIVL_LSB = 0;
  localparam int B_PIN    = 12;
  localparam int B_OD     = 13;
  localparam int B_INV    = 14;
  localparam int B_FORCE  = 15;
  localparam int B_CLK    = 16;
  localparam int B_NOSYNC = 17;

  typedef struct packed {
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] rise;
    logic [CNT_W-1:0] fall;
  } dutyT;

  typedef struct packed {
    logic              syncOff;
    logic              clkOn;
    logic              forceLvl;
    logic              invert;
    logic              openDrain;
    logic              pinOn;
    logic [DIVH_W-1:0] divHi;
    logic [DIVL_W-1:0] divLo;
  } ctrlT;

  typedef struct packed {
    logic loadActive;
    logic takeBus;
    logic holdIdle;
  } strobeT;
endpackage

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_chan_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTRL_OFS = 0,
  parameter int DUTY_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              periodWrap,
  output ctrlT              cfg,
  output dutyT              busDuty,
  output dutyT              pendDuty,
  output strobeT            stb
);
  logic ctrlHit, dutyHit;
  logic unusedBits;

  assign ctrlHit = wrEn && (wrAddr == ADDR_W'(CTRL_OFS));
  assign dutyHit = wrEn && (wrAddr == ADDR_W'(DUTY_OFS));
  assign unusedBits = ^wrData[23:16];

  assign busDuty.period = wrData[PER_LSB +: CNT_W];
  assign busDuty.rise   = wrData[RISE_LSB +: CNT_W];
  assign busDuty.fall   = wrData[FALL_LSB +: CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      pendDuty <= '0;
    end else begin
      if (ctrlHit) begin
        cfg.syncOff   <= wrData[B_NOSYNC];
        cfg.clkOn     <= wrData[B_CLK];
        cfg.forceLvl  <= wrData[B_FORCE];
        cfg.invert    <= wrData[B_INV];
        cfg.openDrain <= wrData[B_OD];
        cfg.pinOn     <= wrData[B_PIN];
        cfg.divHi     <= wrData[DIVH_LSB +: DIVH_W];
        cfg.divLo     <= wrData[DIVL_LSB +: DIVL_W];
      end
      if (dutyHit) pendDuty <= busDuty;
    end
  end

  // Strobes: when the datapath copies a duty set, and from where.
  assign stb.takeBus    = dutyHit;
  assign stb.loadActive = cfg.syncOff || !cfg.clkOn || periodWrap;
  assign stb.holdIdle   = !cfg.clkOn;

  assert_stray_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !ctrlHit && !dutyHit) |=> ($stable(cfg) && $stable(pendDuty)));

  assert_ctrl_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlHit |=> (cfg.clkOn == $past(wrData[B_CLK])));
endmodule

// File: rtl/pwm_chan_prescale.sv
module pwm_chan_prescale
  import pwm_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [DIVH_W-1:0] divHi,
  input  logic [DIVL_W-1:0] divLo,
  output logic              tick
);
  logic [DIVL_W-1:0] lowCnt;
  logic [HI_W-1:0]   hiCnt;
  logic [HI_W-1:0]   hiMask;
  logic              lowWrap, hiWrap;

  assign hiMask  = ~({HI_W{1'b1}} << divHi);
  assign lowWrap = (lowCnt >= divLo);
  assign hiWrap  = (hiCnt >= hiMask);
  assign tick    = !clear && lowWrap && hiWrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowCnt <= '0;
      hiCnt  <= '0;
    end else if (clear) begin
      lowCnt <= '0;
      hiCnt  <= '0;
    end else if (lowWrap) begin
      lowCnt <= '0;
      hiCnt  <= hiWrap ? '0 : hiCnt + 1'b1;
    end else begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (lowCnt == '0 && hiCnt == '0));

  assert_tick_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (lowCnt == '0 && hiCnt == '0));
endmodule

// File: rtl/pwm_chan_datapath.sv
module pwm_chan_datapath
  import pwm_chan_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ctrlT   cfg,
  input  dutyT   busDuty,
  input  dutyT   pendDuty,
  input  strobeT stb,
  input  logic   tick,
  output logic   periodWrap,
  output logic   pinOut,
  output logic   pinOe
);
  dutyT             act;
  logic [CNT_W-1:0] cnt;
  logic             inWin, wave, level;

  assign periodWrap = tick && (cnt >= act.period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= '0;
      cnt <= '0;
    end else begin
      if (stb.loadActive) act <= stb.takeBus ? busDuty : pendDuty;
      if (stb.holdIdle)   cnt <= '0;
      else if (tick)      cnt <= periodWrap ? '0 : cnt + 1'b1;
    end
  end

  always_comb begin
    if (act.fall < act.rise)      inWin = (cnt >= act.fall) && (cnt < act.rise);
    else if (act.fall > act.rise) inWin = (cnt >= act.fall) || (cnt < act.rise);
    else                          inWin = 1'b0;
  end

  assign wave   = inWin && cfg.clkOn && !cfg.forceLvl;
  assign level  = wave ^ cfg.invert;
  assign pinOut = level;
  assign pinOe  = cfg.pinOn && !(cfg.openDrain && level);

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (periodWrap && !stb.holdIdle) |=> (cnt == '0));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !periodWrap && !stb.holdIdle) |=> (cnt == $past(cnt) + 1'b1));

  assert_hold_shadow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.clkOn && !cfg.syncOff && !periodWrap) |=> $stable(act));

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.clkOn |-> (pinOut == cfg.invert));

  always_comb begin
    if (rst_n && pinOe && cfg.openDrain)
      assert_od_release_R9: assert (!pinOut);
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTRL_OFS = 0,
  parameter int DUTY_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  output logic              pinOut,
  output logic              pinOe
);
  ctrlT   cfg;
  dutyT   busDuty, pendDuty;
  strobeT stb;
  logic   tick, periodWrap;

  pwm_chan_ctrl #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .DUTY_OFS(DUTY_OFS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .periodWrap(periodWrap), .cfg(cfg), .busDuty(busDuty), .pendDuty(pendDuty), .stb(stb)
  );

  pwm_chan_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .clear(stb.holdIdle),
    .divHi(cfg.divHi), .divLo(cfg.divLo), .tick(tick)
  );

  pwm_chan_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .busDuty(busDuty), .pendDuty(pendDuty),
    .stb(stb), .tick(tick), .periodWrap(periodWrap), .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: tb/pwm_chan_tb.sv
module pwm_chan_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        pinOut, pinOe;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  // behavioural reference state
  int mCtrl = 0;
  int mPend[3] = '{0, 0, 0};
  int mAct[3]  = '{0, 0, 0};
  int mDiv = 0;
  int mCnt = 0;

  pwm_chan u_dut (.clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
                  .wrData(wrData), .pinOut(pinOut), .pinOe(pinOe));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int bitOf(int w, int b);
    return (w >> b) & 1;
  endfunction

  function automatic logic [31:0] mkCtrl(int nosync, int ce, int frc, int inv, int od,
                                         int pe, int h, int l);
    return 32'(nosync << 17 | ce << 16 | frc << 15 | inv << 14 | od << 13 | pe << 12
               | h << 8 | l) | 32'hFFF0_0000;
  endfunction

  function automatic logic [31:0] mkDuty(int p, int r, int f);
    return 32'(p << 24 | 8'h5A << 16 | r << 8 | f);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mCtrl = 0; mPend = '{0, 0, 0}; mAct = '{0, 0, 0}; mDiv = 0; mCnt = 0;
    end else begin
      int ce, len, tck, wrp, dw;
      int nd[3];
      ce  = bitOf(mCtrl, 16);
      len = (1 << ((mCtrl >> 8) & 15)) * ((mCtrl & 255) + 1);
      tck = ce && (mDiv == len - 1);
      wrp = tck && (mCnt >= mAct[0]);
      dw  = wrEn && wrAddr == 4'h4;
      nd  = '{int'(wrData[31:24]), int'(wrData[15:8]), int'(wrData[7:0])};
      if (bitOf(mCtrl, 17) || !ce || wrp) mAct = dw ? nd : mPend;
      if (dw) mPend = nd;
      if (!ce) begin mCnt = 0; mDiv = 0; end
      else if (tck) begin mCnt = wrp ? 0 : mCnt + 1; mDiv = 0; end
      else mDiv = mDiv + 1;
      if (wrEn && wrAddr == 4'h0) mCtrl = int'(wrData[17:0]);
    end
  end

  always @(negedge clk) begin
    int win, lvl, oe;
    if (mAct[2] < mAct[1])      win = (mCnt >= mAct[2]) && (mCnt < mAct[1]);
    else if (mAct[2] > mAct[1]) win = (mCnt >= mAct[2]) || (mCnt < mAct[1]);
    else                        win = 0;
    win = win && bitOf(mCtrl, 16) && !bitOf(mCtrl, 15);
    lvl = win ^ bitOf(mCtrl, 14);
    oe  = bitOf(mCtrl, 12) && !(bitOf(mCtrl, 13) && lvl);
    checks++;
    if (pinOut !== 1'(lvl) || pinOe !== 1'(oe)) begin
      fails++;
      $display("FAIL %s t=%0t pinOut/pinOe actual %b/%b expected %0d/%0d",
               curReq, $time, pinOut, pinOe, lvl, oe);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic directed(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s directed actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic highRun(output int len);
    len = 0;
    while (pinOut !== 1'b0) @(negedge clk);
    while (pinOut !== 1'b1) @(negedge clk);
    while (pinOut === 1'b1) begin len++; @(negedge clk); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int len, hi;
    idle(3);
    directed("R1", int'(pinOe), 0);
    rst_n = 1'b1;
    idle(3);
    directed("R1", int'(pinOut), 0);

    // R2 R3 R4: divider 2^1*3 = 6 clocks, period 10 ticks, high 4 ticks
    curReq = "R2";
    wr(4'h4, mkDuty(9, 4, 0));
    wr(4'h0, mkCtrl(0, 1, 0, 0, 0, 1, 1, 2));
    highRun(len);
    directed("R2", len, 24);
    curReq = "R3";
    idle(200);

    // R10: wrapped window held until wrap
    curReq = "R10";
    idle(17);
    wr(4'h4, mkDuty(9, 2, 7));
    idle(250);
    curReq = "R4";
    highRun(len);
    directed("R4", len, 30);
    wr(4'h4, mkDuty(9, 3, 3));
    idle(130);
    hi = 0;
    repeat (120) begin @(negedge clk); hi += int'(pinOut); end
    directed("R4", hi, 0);

    // conditioning
    wr(4'h4, mkDuty(5, 3, 0));
    idle(80);
    curReq = "R7";
    wr(4'h0, mkCtrl(0, 1, 0, 1, 0, 1, 1, 2));
    idle(120);
    curReq = "R8";
    wr(4'h0, mkCtrl(0, 1, 1, 1, 0, 1, 1, 2));
    idle(10);
    directed("R8", int'(pinOut), 1);
    curReq = "R9";
    wr(4'h0, mkCtrl(0, 1, 0, 0, 1, 1, 1, 2));
    idle(120);
    curReq = "R6";
    wr(4'h0, mkCtrl(0, 1, 0, 0, 0, 0, 1, 2));
    idle(60);
    directed("R6", int'(pinOe), 0);

    // R11 immediate duty, R13 period shrink
    curReq = "R11";
    wr(4'h0, mkCtrl(1, 1, 0, 0, 0, 1, 0, 1));
    wr(4'h4, mkDuty(200, 100, 10));
    idle(150);
    curReq = "R13";
    wr(4'h4, mkDuty(20, 8, 0));
    idle(120);

    // R12 stray offsets
    curReq = "R12";
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'hC, 32'h0000_0000);
    wr(4'h2, 32'h0);
    idle(100);

    // R5 clock disable mid-run, duty follows on next edge
    curReq = "R5";
    wr(4'h0, mkCtrl(0, 0, 0, 0, 0, 1, 0, 1));
    wr(4'h4, mkDuty(7, 0, 1));
    idle(30);
    directed("R5", int'(pinOut), 0);
    curReq = "R10";
    wr(4'h0, mkCtrl(0, 1, 0, 0, 0, 1, 2, 0));
    idle(150);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule